// File: doc/BRIEF.md
# Macro Call Parameter Collector

This block sits in the register-write path of one engine. Each incoming write carries a method number, a data word and a count of the writes still to come in the same burst. Methods below the macro range go to a local register file. Methods at or above the macro base (0xE00) never reach the register file. Instead they open or extend a macro call.

A call opens with a write to an even trigger method. After that, only the next odd method (the trigger plus one) may carry further arguments. The block collects every value of the call, starting with the one written to the trigger, in a parameter buffer. The write whose remaining count is zero ends the call. If code has been uploaded for that macro, the block raises a call request toward a downstream executor. The request carries the trigger method, the parameter count and a read port into the buffer, and it is held until the executor acknowledges it.

An upload path marks each macro slot as loaded. Protocol errors, calls to macros with no code and parameter overflow are each reported by a one-cycle pulse.

Top module: `macro_call_collector`

## Requirements
- R1: After reset, `call_valid` and all three error pulses are 0, `wr_ready` is 1, no macro slot is marked loaded, and every register file entry reads 0.
- R2: A write to a method below `REG_COUNT` (256) stores the value at that index, readable on `rf_rd_data` from the next cycle. A write to a method at or above `REG_COUNT` and below 0xE00 changes no register file entry.
- R3: A write to any method at or above 0xE00 changes no register file entry, including the entry equal to the method's low bits.
- R4: With no call open, a write to an even method at or above 0xE00 opens a call on that method, and its value becomes parameter 0.
- R5: With no call open, a write to an odd method at or above 0xE00 pulses `err_order` for one cycle in the cycle after it is accepted, and opens no call.
- R6: While a call is open, a write to any method other than the trigger plus one pulses `err_order` the next cycle. The write is dropped: it is neither stored nor appended, and the call stays open.
- R7: An in-order write with remaining count 0 to a loaded macro raises `call_valid` the next cycle. The call shows the trigger method, the parameter count and the parameters in arrival order on `call_rd_data` at index `call_rd_idx`. `call_valid` holds with `wr_ready` low until `call_ack` is seen, and both return to idle the cycle after.
- R8: A call ending on a macro whose slot is not loaded pulses `err_unloaded` the next cycle. No request is issued, and the call state clears so the next call starts at parameter 0.
- R9: `up_commit` with `up_slot` = s marks method 0xE00 + 2*s as loaded, from the following cycle on.
- R10: Once 16 parameters are held, each further in-order argument is dropped and pulses `err_overflow` the next cycle. The call still issues, with count 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Write strobe |
| wr_ready | output | 1 | Write accepted when high; low while a call request is pending |
| wr_method | input | 12 | Method number of the write |
| wr_value | input | 32 | Data word of the write |
| wr_remaining | input | 8 | Writes still to follow in this burst |
| up_commit | input | 1 | Upload commit pulse |
| up_slot | input | 8 | Slot loaded by the commit (method 0xE00 + 2*slot) |
| rf_rd_addr | input | 8 | Register file read index |
| rf_rd_data | output | 32 | Register file read data |
| call_valid | output | 1 | Call request pending |
| call_ack | input | 1 | Executor acknowledge |
| call_method | output | 12 | Trigger method of the pending call |
| call_count | output | 5 | Number of parameters in the pending call |
| call_rd_idx | input | 4 | Parameter read index |
| call_rd_data | output | 32 | Parameter at `call_rd_idx` |
| err_order | output | 1 | Ordering error pulse |
| err_unloaded | output | 1 | Call to unloaded macro pulse |
| err_overflow | output | 1 | Parameter overflow pulse |

## Verification
Every result is registered once, so each one is due in the cycle right after the write, commit or acknowledge that causes it. That holds for register file contents, call requests, the return to idle and every error pulse. The bench drives each stimulus on the falling edge and samples one time unit after the next rising edge, which is exactly where that single register stage makes the result visible. Error pulses are also checked again one cycle later, to confirm they lasted only one cycle. Parameter and register contents are read through their combinational read ports after the index settles.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_ISSUE   = 2'd2
  } mcc_state_e;

endpackage

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ent_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[gi] <= '0;
      end else if (ent_en) begin
        ent_q[gi] <= wdata;
      end
    end
  end

  assign rdata = ent_q[raddr];

endmodule

// File: rtl/mcc_slot_table.sv
module mcc_slot_table #(
  parameter int SLOTS  = 256,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [SW-1:0] set_idx,
  input  logic [SW-1:0] look_idx,
  output logic          hit
);

  logic [SLOTS-1:0] loaded_q;
  logic [SLOTS-1:0] loaded_d;

  always_comb begin
    loaded_d = loaded_q;
    if (set_en) begin
      loaded_d[set_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
    end else if (set_en) begin
      loaded_q <= loaded_d;
    end
  end

  assign hit = loaded_q[look_idx];

endmodule

// File: rtl/mcc_param_buf.sv
module mcc_param_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic word_en;
    assign word_en = we && (widx == IW'(gi));
    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q[gi] <= wdata;
      end
    end
  end

  assign rdata = word_q[ridx];

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int METHOD_W    = 12,
  parameter int REM_W       = 8,
  parameter int REG_COUNT   = 256,
  parameter int MACRO_BASE  = 'hE00,
  parameter int PARAM_DEPTH = 16,
  localparam int IW         = $clog2(PARAM_DEPTH),
  localparam int CNT_W      = $clog2(PARAM_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [METHOD_W-1:0] wr_method,
  input  logic [REM_W-1:0]    wr_remaining,
  input  logic                slot_hit,
  input  logic                call_ack,
  output logic                wr_ready,
  output logic [METHOD_W-1:0] look_method,
  output logic                buf_we,
  output logic [IW-1:0]       buf_widx,
  output logic                rf_we,
  output logic                call_valid,
  output logic [METHOD_W-1:0] call_method,
  output logic [CNT_W-1:0]    call_count,
  output logic                err_order,
  output logic                err_unloaded,
  output logic                err_overflow
);

  mcc_state_e          state_q, state_d;
  logic [METHOD_W-1:0] exec_q, exec_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                eo_q, eo_d;
  logic                eu_q, eu_d;
  logic                ev_q, ev_d;

  logic                is_macro;
  logic                in_rf;
  logic                last_w;
  logic [METHOD_W-1:0] arg_method;
  logic                buf_full;

  assign is_macro   = wr_method >= METHOD_W'(MACRO_BASE);
  assign in_rf      = wr_method < METHOD_W'(REG_COUNT);
  assign last_w     = wr_remaining == '0;
  assign arg_method = exec_q + METHOD_W'(1);
  assign buf_full   = cnt_q >= CNT_W'(PARAM_DEPTH);
  assign look_method = (state_q == ST_IDLE) ? wr_method : exec_q;

  always_comb begin
    state_d  = state_q;
    exec_d   = exec_q;
    cnt_d    = cnt_q;
    buf_we   = 1'b0;
    buf_widx = IW'(cnt_q);
    rf_we    = 1'b0;
    eo_d     = 1'b0;
    eu_d     = 1'b0;
    ev_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_valid) begin
          if (is_macro) begin
            if (wr_method[0]) begin
              eo_d = 1'b1;
            end else begin
              buf_we   = 1'b1;
              buf_widx = '0;
              exec_d   = wr_method;
              cnt_d    = CNT_W'(1);
              if (!last_w) begin
                state_d = ST_COLLECT;
              end else if (slot_hit) begin
                state_d = ST_ISSUE;
              end else begin
                eu_d   = 1'b1;
                exec_d = '0;
                cnt_d  = '0;
              end
            end
          end else if (in_rf) begin
            rf_we = 1'b1;
          end
        end
      end
      ST_COLLECT: begin
        if (wr_valid) begin
          if (wr_method != arg_method) begin
            eo_d = 1'b1;
          end else begin
            if (buf_full) begin
              ev_d = 1'b1;
            end else begin
              buf_we = 1'b1;
              cnt_d  = cnt_q + CNT_W'(1);
            end
            if (last_w) begin
              if (slot_hit) begin
                state_d = ST_ISSUE;
              end else begin
                eu_d    = 1'b1;
                exec_d  = '0;
                cnt_d   = '0;
                state_d = ST_IDLE;
              end
            end
          end
        end
      end
      ST_ISSUE: begin
        if (call_ack) begin
          state_d = ST_IDLE;
          exec_d  = '0;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      exec_q  <= '0;
      cnt_q   <= '0;
      eo_q    <= 1'b0;
      eu_q    <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      exec_q  <= exec_d;
      cnt_q   <= cnt_d;
      eo_q    <= eo_d;
      eu_q    <= eu_d;
      ev_q    <= ev_d;
    end
  end

  assign wr_ready     = state_q != ST_ISSUE;
  assign call_valid   = state_q == ST_ISSUE;
  assign call_method  = exec_q;
  assign call_count   = cnt_q;
  assign err_order    = eo_q;
  assign err_unloaded = eu_q;
  assign err_overflow = ev_q;

endmodule

// File: rtl/macro_call_collector.sv
module macro_call_collector #(
  parameter int METHOD_W    = 12,
  parameter int DATA_W      = 32,
  parameter int REM_W       = 8,
  parameter int REG_COUNT   = 256,
  parameter int MACRO_BASE  = 'hE00,
  parameter int PARAM_DEPTH = 16,
  localparam int RF_AW      = $clog2(REG_COUNT),
  localparam int SLOTS      = ((1 << METHOD_W) - MACRO_BASE) / 2,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int IW         = $clog2(PARAM_DEPTH),
  localparam int CNT_W      = $clog2(PARAM_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [METHOD_W-1:0] wr_method,
  input  logic [DATA_W-1:0]   wr_value,
  input  logic [REM_W-1:0]    wr_remaining,
  input  logic                up_commit,
  input  logic [SLOT_W-1:0]   up_slot,
  input  logic [RF_AW-1:0]    rf_rd_addr,
  output logic [DATA_W-1:0]   rf_rd_data,
  output logic                call_valid,
  input  logic                call_ack,
  output logic [METHOD_W-1:0] call_method,
  output logic [CNT_W-1:0]    call_count,
  input  logic [IW-1:0]       call_rd_idx,
  output logic [DATA_W-1:0]   call_rd_data,
  output logic                err_order,
  output logic                err_unloaded,
  output logic                err_overflow
);

  logic                rst_s1_q, rst_s2_q;
  logic                rst_int_n;
  logic                acc_valid;
  logic [METHOD_W-1:0] look_method;
  logic [METHOD_W-1:0] look_off;
  logic [SLOT_W-1:0]   look_slot;
  logic                slot_hit;
  logic                buf_we;
  logic [IW-1:0]       buf_widx;
  logic                rf_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  assign acc_valid = wr_valid && wr_ready;
  assign look_off  = look_method - METHOD_W'(MACRO_BASE);
  assign look_slot = SLOT_W'(look_off >> 1);

  mcc_ctrl #(
    .METHOD_W    (METHOD_W),
    .REM_W       (REM_W),
    .REG_COUNT   (REG_COUNT),
    .MACRO_BASE  (MACRO_BASE),
    .PARAM_DEPTH (PARAM_DEPTH)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_valid     (acc_valid),
    .wr_method    (wr_method),
    .wr_remaining (wr_remaining),
    .slot_hit     (slot_hit),
    .call_ack     (call_ack),
    .wr_ready     (wr_ready),
    .look_method  (look_method),
    .buf_we       (buf_we),
    .buf_widx     (buf_widx),
    .rf_we        (rf_we),
    .call_valid   (call_valid),
    .call_method  (call_method),
    .call_count   (call_count),
    .err_order    (err_order),
    .err_unloaded (err_unloaded),
    .err_overflow (err_overflow)
  );

  mcc_slot_table #(
    .SLOTS (SLOTS)
  ) u_slots (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_en   (up_commit),
    .set_idx  (up_slot),
    .look_idx (look_slot),
    .hit      (slot_hit)
  );

  mcc_param_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (PARAM_DEPTH)
  ) u_pbuf (
    .clk   (clk),
    .we    (buf_we),
    .widx  (buf_widx),
    .wdata (wr_value),
    .ridx  (call_rd_idx),
    .rdata (call_rd_data)
  );

  mcc_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (REG_COUNT)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (rf_we),
    .waddr (RF_AW'(wr_method)),
    .wdata (wr_value),
    .raddr (rf_rd_addr),
    .rdata (rf_rd_data)
  );

endmodule

// File: rtl/mcc_chk.sv
module mcc_chk #(
  parameter int METHOD_W    = 12,
  parameter int REM_W       = 8,
  parameter int MACRO_BASE  = 'hE00,
  parameter int PARAM_DEPTH = 16,
  localparam int CNT_W      = $clog2(PARAM_DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [METHOD_W-1:0] wr_method,
  input logic [REM_W-1:0]    wr_remaining,
  input logic                call_valid,
  input logic                call_ack,
  input logic [METHOD_W-1:0] call_method,
  input logic [CNT_W-1:0]    call_count,
  input logic                err_order,
  input logic                err_unloaded,
  input logic                err_overflow
);

  // R7
  call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !call_ack |=> call_valid && $stable(call_method) && $stable(call_count));

  // R7
  call_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> !wr_ready);

  // R7
  call_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> $past(wr_valid && wr_ready && wr_remaining == '0));

  // R4
  call_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> (call_method >= METHOD_W'(MACRO_BASE)) && !call_method[0] && (call_count != '0));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> call_count <= CNT_W'(PARAM_DEPTH));

  // R8
  unloaded_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_unloaded |-> $past(wr_valid && wr_ready && wr_remaining == '0));

  // R5
  order_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_order |-> $past(wr_valid && wr_ready));

  // R10
  overflow_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> $past(wr_valid && wr_ready && wr_method >= METHOD_W'(MACRO_BASE)));

endmodule

bind macro_call_collector mcc_chk #(
  .METHOD_W    (METHOD_W),
  .REM_W       (REM_W),
  .MACRO_BASE  (MACRO_BASE),
  .PARAM_DEPTH (PARAM_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_method    (wr_method),
  .wr_remaining (wr_remaining),
  .call_valid   (call_valid),
  .call_ack     (call_ack),
  .call_method  (call_method),
  .call_count   (call_count),
  .err_order    (err_order),
  .err_unloaded (err_unloaded),
  .err_overflow (err_overflow)
);

// File: tb/tb_macro_call_collector.sv
module tb_macro_call_collector;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [11:0] wr_method;
  logic [31:0] wr_value;
  logic [7:0]  wr_remaining;
  logic        up_commit;
  logic [7:0]  up_slot;
  logic [7:0]  rf_rd_addr;
  logic [31:0] rf_rd_data;
  logic        call_valid;
  logic        call_ack;
  logic [11:0] call_method;
  logic [4:0]  call_count;
  logic [3:0]  call_rd_idx;
  logic [31:0] call_rd_data;
  logic        err_order;
  logic        err_unloaded;
  logic        err_overflow;

  int checks;
  int failures;
  bit done;

  macro_call_collector dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_method    (wr_method),
    .wr_value     (wr_value),
    .wr_remaining (wr_remaining),
    .up_commit    (up_commit),
    .up_slot      (up_slot),
    .rf_rd_addr   (rf_rd_addr),
    .rf_rd_data   (rf_rd_data),
    .call_valid   (call_valid),
    .call_ack     (call_ack),
    .call_method  (call_method),
    .call_count   (call_count),
    .call_rd_idx  (call_rd_idx),
    .call_rd_data (call_rd_data),
    .err_order    (err_order),
    .err_unloaded (err_unloaded),
    .err_overflow (err_overflow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] m, input logic [31:0] v, input logic [7:0] r);
    @(negedge clk);
    wr_valid = 1'b1; wr_method = m; wr_value = v; wr_remaining = r;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_upload(input logic [7:0] s);
    @(negedge clk);
    up_commit = 1'b1; up_slot = s;
    @(posedge clk);
    #1;
    up_commit = 1'b0;
  endtask

  task automatic do_ack(input string req);
    @(negedge clk);
    call_ack = 1'b1;
    @(posedge clk);
    #1;
    call_ack = 1'b0;
    chk({req, " call_valid after ack"}, 32'(call_valid), 32'd0);
    chk({req, " wr_ready after ack"}, 32'(wr_ready), 32'd1);
  endtask

  task automatic rd_rf(input logic [7:0] a, output logic [31:0] d);
    rf_rd_addr = a;
    #1;
    d = rf_rd_data;
  endtask

  task automatic rd_par(input logic [3:0] i, output logic [31:0] d);
    call_rd_idx = i;
    #1;
    d = call_rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 call_valid", 32'(call_valid), 32'd0);
    chk("R1 wr_ready", 32'(wr_ready), 32'd1);
    chk("R1 errors", {29'd0, err_order, err_unloaded, err_overflow}, 32'd0);
    rd_rf(8'h03, d);
    chk("R1 rf reset", d, 32'd0);
  endtask

  task automatic t_regfile;
    logic [31:0] d;
    do_write(12'h003, 32'hA5A5_0003, 8'd0);
    rd_rf(8'h03, d);
    chk("R2 rf write 0x03", d, 32'hA5A5_0003);
    do_write(12'h0FF, 32'h0000_0077, 8'd0);
    rd_rf(8'hFF, d);
    chk("R2 rf write 0xFF", d, 32'h0000_0077);
    do_write(12'h103, 32'h1234_5678, 8'd0);
    rd_rf(8'h03, d);
    chk("R2 out-of-range write ignored", d, 32'hA5A5_0003);
    chk("R2 no call", 32'(call_valid), 32'd0);
  endtask

  task automatic t_single_call;
    logic [31:0] d;
    do_write(12'hE00, 32'h0000_0011, 8'd0);
    chk("R7 single call_valid", 32'(call_valid), 32'd1);
    chk("R7 single method", 32'(call_method), 32'hE00);
    chk("R7 single count", 32'(call_count), 32'd1);
    chk("R7 wr_ready low", 32'(wr_ready), 32'd0);
    rd_par(4'd0, d);
    chk("R4 param0", d, 32'h11);
    rd_rf(8'h00, d);
    chk("R3 macro not in rf", d, 32'd0);
    @(negedge clk);
    chk("R7 held without ack", 32'(call_valid), 32'd1);
    do_ack("R7");
  endtask

  task automatic t_multi_call;
    logic [31:0] d;
    do_write(12'hE04, 32'd10, 8'd3);
    chk("R4 no call yet", 32'(call_valid), 32'd0);
    do_write(12'hE05, 32'd20, 8'd2);
    do_write(12'hE05, 32'd30, 8'd1);
    chk("R4 still open", 32'(call_valid), 32'd0);
    do_write(12'hE05, 32'd40, 8'd0);
    chk("R7 multi call_valid", 32'(call_valid), 32'd1);
    chk("R7 multi method", 32'(call_method), 32'hE04);
    chk("R7 multi count", 32'(call_count), 32'd4);
    for (int i = 0; i < 4; i++) begin
      rd_par(4'(i), d);
      chk("R7 multi param", d, 32'(10 * (i + 1)));
    end
    rd_rf(8'h05, d);
    chk("R3 arg not in rf", d, 32'd0);
    do_ack("R7");
  endtask

  task automatic t_odd_start;
    do_write(12'hE05, 32'hDEAD, 8'd0);
    chk("R5 err_order", 32'(err_order), 32'd1);
    chk("R5 no call", 32'(call_valid), 32'd0);
    @(posedge clk);
    #1;
    chk("R5 pulse one cycle", 32'(err_order), 32'd0);
    do_write(12'hE0A, 32'h55, 8'd0);
    chk("R5 later call count", 32'(call_count), 32'd1);
    chk("R5 later call method", 32'(call_method), 32'hE0A);
    do_ack("R5");
  endtask

  task automatic t_wrong_method;
    logic [31:0] d;
    do_write(12'hE04, 32'd1, 8'd2);
    do_write(12'h010, 32'd99, 8'd0);
    chk("R6 err_order on rf method", 32'(err_order), 32'd1);
    chk("R6 call still open", 32'(call_valid), 32'd0);
    rd_rf(8'h10, d);
    chk("R6 dropped write not stored", d, 32'd0);
    do_write(12'hE05, 32'd2, 8'd1);
    chk("R6 pulse cleared", 32'(err_order), 32'd0);
    do_write(12'hE07, 32'd77, 8'd0);
    chk("R6 err_order on other arg", 32'(err_order), 32'd1);
    chk("R6 still open", 32'(call_valid), 32'd0);
    do_write(12'hE05, 32'd3, 8'd0);
    chk("R6 call issued", 32'(call_valid), 32'd1);
    chk("R6 count", 32'(call_count), 32'd3);
    rd_par(4'd2, d);
    chk("R6 param2", d, 32'd3);
    do_ack("R6");
  endtask

  task automatic t_unloaded;
    logic [31:0] d;
    do_write(12'hE02, 32'd5, 8'd1);
    do_write(12'hE03, 32'd6, 8'd0);
    chk("R8 err_unloaded", 32'(err_unloaded), 32'd1);
    chk("R8 no call", 32'(call_valid), 32'd0);
    chk("R8 wr_ready", 32'(wr_ready), 32'd1);
    do_write(12'hE04, 32'h77, 8'd0);
    chk("R8 fresh call count", 32'(call_count), 32'd1);
    rd_par(4'd0, d);
    chk("R8 fresh param0", d, 32'h77);
    do_ack("R8");
  endtask

  task automatic t_upload;
    do_upload(8'd1);
    do_write(12'hE02, 32'd9, 8'd0);
    chk("R9 newly loaded call", 32'(call_valid), 32'd1);
    chk("R9 method", 32'(call_method), 32'hE02);
    chk("R9 no unloaded err", 32'(err_unloaded), 32'd0);
    do_ack("R9");
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    do_write(12'hE00, 32'd100, 8'd17);
    for (int k = 1; k <= 15; k++) begin
      do_write(12'hE01, 32'(100 + k), 8'(17 - k));
    end
    chk("R10 no overflow at 16", 32'(err_overflow), 32'd0);
    do_write(12'hE01, 32'd116, 8'd1);
    chk("R10 err_overflow", 32'(err_overflow), 32'd1);
    do_write(12'hE01, 32'd117, 8'd0);
    chk("R10 err_overflow last", 32'(err_overflow), 32'd1);
    chk("R10 call issued", 32'(call_valid), 32'd1);
    chk("R10 count saturated", 32'(call_count), 32'd16);
    rd_par(4'd15, d);
    chk("R10 param15", d, 32'd115);
    rd_par(4'd0, d);
    chk("R10 param0", d, 32'd100);
    do_ack("R10");
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_method = '0; wr_value = '0; wr_remaining = '0;
    up_commit = 1'b0; up_slot = '0; rf_rd_addr = '0;
    call_ack = 1'b0; call_rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    do_upload(8'd0);
    do_upload(8'd2);
    do_upload(8'd5);
    t_regfile();
    t_single_call();
    t_multi_call();
    t_odd_start();
    t_wrong_method();
    t_unloaded();
    t_upload();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule